// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit core's memory stage and a word-wide data memory. The memory is byte-addressed and uses big-endian byte order. For each access the unit forms the effective address from a base register value and a signed 16-bit displacement, and it drives the word address to memory. It also drives a per-lane byte-enable and, for stores, a write strobe and write data with the value placed in the right lanes. Sub-word loads and stores need no read-modify-write in the core.

Loads use a memory that returns the addressed word one clock after the request. On that request cycle the unit registers the access size, the extension mode and the byte offset. In the following cycle it selects the addressed byte, halfword or word from the returned word. It then sign- or zero-extends the selection to 32 bits and presents it together with a valid strobe. The unit flags a halfword access at an odd address, or a word access off a 4-byte boundary, and suppresses it so that memory is never touched by it.

Top module: `lsa_unit`

## Requirements
- R1: The byte address is `base_val` plus `ofs_imm` sign-extended to 32 bits. `mem_addr` carries that address with bits 1:0 cleared.
- R2: Byte lanes are big-endian. Byte offset 0 is bits 31:24 and is enabled by `mem_be[3]`, and offset 3 is bits 7:0 and is enabled by `mem_be[0]`. A byte access enables exactly one lane. A halfword access enables `4'b1100` at offset 0 and `4'b0011` at offset 2. A word access enables `4'b1111`.
- R3: A store byte (op 0x28) repeats `st_data[7:0]` in all four lanes of `mem_wdata`. A store halfword (op 0x29) repeats `st_data[15:0]` in both halves. A store word (op 0x2B) passes `st_data` through unchanged.
- R4: A store writes only the enabled lanes, so the other bytes of the word keep their value. `mem_we` is high only for an accepted store.
- R5: Load byte (op 0x20) and load halfword (op 0x21) return the selected data sign-extended to 32 bits. The result appears on `ld_result` with `ld_valid` high in the cycle after the request.
- R6: Load byte unsigned (op 0x24) and load halfword unsigned (op 0x25) return the selected data zero-extended, with the same timing as R5.
- R7: Load word (op 0x23) returns the whole memory word in the cycle after the request, with `ld_valid` high.
- R8: For a halfword access at an odd address, or a word access whose address is not a multiple of 4, `misalign` is high in the request cycle. `mem_be` is then zero and `mem_we` is low, and no `ld_valid` follows.
- R9: An opcode outside the eight listed above produces no lane enables, no write, no misalign flag and no load result.
- R10: After reset, `ld_valid` is low and `ld_result` is zero until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| op_code | input | 6 | Access opcode |
| base_val | input | 32 | Base register value |
| ofs_imm | input | 16 | Signed displacement |
| st_data | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory one cycle after the request |
| mem_addr | output | 32 | Word-aligned byte address to memory |
| mem_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Lane-placed store data |
| ld_result | output | 32 | Extended load result |
| ld_valid | output | 1 | `ld_result` holds a load result |
| misalign | output | 1 | Request address is misaligned for its size |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 16-bit displacement and a 32-bit data path of four lanes. With those defaults the bench can reach every lane offset for every size. That coverage includes both halfword positions and every misaligned offset for halfword and word accesses. It also reaches negative displacements that carry across the base and data bytes whose top bit separates sign extension from zero extension. A small word array with byte-lane writes and a one-cycle registered read stands in for memory, so the store-then-load sequences show which bytes each store kept.

// File: rtl/lsa_pkg.sv
// Shared opcodes, access-size type and opcode decoder for the load/store
// alignment unit. Assumes the 6-bit primary opcode field of the core.
package lsa_pkg;

    localparam logic [5:0] OP_LB  = 6'h20;
    localparam logic [5:0] OP_LH  = 6'h21;
    localparam logic [5:0] OP_LW  = 6'h23;
    localparam logic [5:0] OP_LBU = 6'h24;
    localparam logic [5:0] OP_LHU = 6'h25;
    localparam logic [5:0] OP_SB  = 6'h28;
    localparam logic [5:0] OP_SH  = 6'h29;
    localparam logic [5:0] OP_SW  = 6'h2B;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } lsa_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        logic      sign_ext;
        lsa_size_e size;
    } lsa_dec_t;

    // Map an opcode onto direction, size and extension mode.
    function automatic lsa_dec_t lsa_decode(input logic [5:0] op);
        lsa_dec_t d;
        d = '{is_load: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_NONE};
        case (op)
            OP_LB:  d = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_BYTE};
            OP_LH:  d = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_HALF};
            OP_LW:  d = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
            OP_LBU: d = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
            OP_LHU: d = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_HALF};
            OP_SB:  d = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
            OP_SH:  d = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_HALF};
            OP_SW:  d = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
// Effective address generator: adds the sign-extended displacement to the
// base, splits the sum into a word address and a lane offset, and checks
// natural alignment for the access size. Purely combinational.
// Assumes ADDR_W > IMM_W.
module lsa_addr_gen
    import lsa_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 16,
    parameter int LANE_AW = 2
) (
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [IMM_W-1:0]   ofs_imm,
    input  lsa_size_e          size,
    output logic [ADDR_W-1:0]  word_addr,
    output logic [LANE_AW-1:0] lane_ofs,
    output logic               misaligned
);

    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] byte_addr;

    // Sign-extend the displacement and form the byte address.
    always_comb begin
        imm_ext   = {{EXT_W{ofs_imm[IMM_W-1]}}, ofs_imm};
        byte_addr = base_val + imm_ext;
        word_addr = {byte_addr[ADDR_W-1:LANE_AW], {LANE_AW{1'b0}}};
        lane_ofs  = byte_addr[LANE_AW-1:0];
    end

    // Natural alignment: halfwords on even offsets, words on lane 0.
    always_comb begin
        case (size)
            SZ_HALF: misaligned = lane_ofs[0];
            SZ_WORD: misaligned = |lane_ofs;
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsa_store_lane.sv
// Store-side lane steering: produces big-endian byte enables and places the
// store value into the lanes it will occupy. Lane l (byte offset l) sits at
// bits [(LANES-1-l)*8 +: 8] and is enabled by be[LANES-1-l].
// Assumes halfwords are two lanes and a word is the full data width.
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_AW = $clog2(LANES)
) (
    input  logic               active,
    input  lsa_size_e          size,
    input  logic [LANE_AW-1:0] lane_ofs,
    input  logic [DATA_W-1:0]  st_data,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [LANE_AW-1:0] LID = LANE_AW'(l);
        localparam int                 POS = (LANES - 1 - l) * 8;

        logic hit;

        // Decide whether this lane belongs to the addressed item.
        always_comb begin
            case (size)
                SZ_BYTE: hit = (lane_ofs == LID);
                SZ_HALF: hit = (lane_ofs[LANE_AW-1:1] == LID[LANE_AW-1:1]);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        assign be[LANES-1-l] = active & hit;

        // Route the store value into this lane.
        always_comb begin
            case (size)
                SZ_BYTE: wdata[POS +: 8] = st_data[7:0];
                SZ_HALF: wdata[POS +: 8] = LID[0] ? st_data[7:0] : st_data[15:8];
                default: wdata[POS +: 8] = st_data[POS +: 8];
            endcase
        end
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Load-side return path: registers size, extension mode and lane offset of
// an accepted load, then picks and extends the item from the word that
// memory returns one cycle later. Assumes a one-cycle read latency.
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LANES   = DATA_W / 8,
    parameter int LANE_AW = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  lsa_size_e          size,
    input  logic               sign_ext,
    input  logic [LANE_AW-1:0] lane_ofs,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  ld_result,
    output logic               ld_valid
);

    logic               vld_q;
    lsa_size_e          size_q;
    logic               sext_q;
    logic [LANE_AW-1:0] ofs_q;
    logic [7:0]         lane_byte [LANES];
    logic [7:0]         sel_b;
    logic [15:0]        sel_h;

    // Hold the shape of the outstanding load for its return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            size_q <= SZ_NONE;
            sext_q <= 1'b0;
            ofs_q  <= '0;
        end else begin
            vld_q <= capture;
            if (capture) begin
                size_q <= size;
                sext_q <= sign_ext;
                ofs_q  <= lane_ofs;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_split
        assign lane_byte[l] = mem_rdata[(LANES-1-l)*8 +: 8];
    end

    // Select the addressed byte and halfword in big-endian order.
    always_comb begin
        sel_b = lane_byte[ofs_q];
        sel_h = {lane_byte[{ofs_q[LANE_AW-1:1], 1'b0}],
                 lane_byte[{ofs_q[LANE_AW-1:1], 1'b1}]};
    end

    // Extend the selection to the full width; zero when nothing returns.
    always_comb begin
        ld_result = '0;
        if (vld_q) begin
            case (size_q)
                SZ_BYTE: ld_result = {{(DATA_W-8){sext_q & sel_b[7]}}, sel_b};
                SZ_HALF: ld_result = {{(DATA_W-16){sext_q & sel_h[15]}}, sel_h};
                default: ld_result = mem_rdata;
            endcase
        end
    end

    assign ld_valid = vld_q;

endmodule

// File: rtl/lsa_unit.sv
// Top of the big-endian load/store alignment unit. Decodes the opcode,
// forms and checks the address, steers store lanes and extracts loads.
// Assumes a word memory with lane write enables and one-cycle read latency.
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        op_code,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IMM_W-1:0]  ofs_imm,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ld_result,
    output logic              ld_valid,
    output logic              misalign
);

    localparam int LANES   = DATA_W / 8;
    localparam int LANE_AW = $clog2(LANES);

    lsa_dec_t           dec;
    logic [LANE_AW-1:0] lane_ofs;
    logic               bad_align;
    logic               is_mem;
    logic               active;

    // Decode and qualify the request.
    always_comb begin
        dec      = lsa_decode(op_code);
        is_mem   = req_valid & (dec.is_load | dec.is_store);
        misalign = is_mem & bad_align;
        active   = is_mem & ~bad_align;
        mem_we   = active & dec.is_store;
    end

    lsa_addr_gen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .LANE_AW(LANE_AW)
    ) u_addr (
        .base_val  (base_val),
        .ofs_imm   (ofs_imm),
        .size      (dec.size),
        .word_addr (mem_addr),
        .lane_ofs  (lane_ofs),
        .misaligned(bad_align)
    );

    lsa_store_lane #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LANE_AW(LANE_AW)
    ) u_store (
        .active  (active),
        .size    (dec.size),
        .lane_ofs(lane_ofs),
        .st_data (st_data),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    lsa_load_extract #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LANE_AW(LANE_AW)
    ) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (active & dec.is_load),
        .size     (dec.size),
        .sign_ext (dec.sign_ext),
        .lane_ofs (lane_ofs),
        .mem_rdata(mem_rdata),
        .ld_result(ld_result),
        .ld_valid (ld_valid)
    );

endmodule

// File: rtl/lsa_unit_chk.sv
// Protocol checker for lsa_unit, attached by bind. Observes ports only.
module lsa_unit_chk
    import lsa_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [5:0] op_code,
    input logic [1:0] addr_lo,
    input logic [3:0] mem_be,
    input logic       mem_we,
    input logic       misalign,
    input logic       ld_valid
);

    logic op_byte, op_load, op_known;

    // Classify the opcode on the port.
    always_comb begin
        op_byte  = (op_code == OP_LB) || (op_code == OP_LBU) || (op_code == OP_SB);
        op_load  = (op_code == OP_LB) || (op_code == OP_LH) || (op_code == OP_LW) ||
                   (op_code == OP_LBU) || (op_code == OP_LHU);
        op_known = op_load || (op_code == OP_SB) || (op_code == OP_SH) || (op_code == OP_SW);
    end

    a_r1_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lo == 2'b00);

    a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_byte) |-> $countones(mem_be) == 1);

    a_r4_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_be != 4'b0000);

    a_r8_misalign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == 4'b0000 && !mem_we));

    a_r8_misalign_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !ld_valid);

    a_r7_load_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_load && !misalign) |=> ld_valid);

    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op_known) |-> (mem_be == 4'b0000 && !mem_we && !misalign));

endmodule

bind lsa_unit lsa_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .op_code  (op_code),
    .addr_lo  (mem_addr[1:0]),
    .mem_be   (mem_be),
    .mem_we   (mem_we),
    .misalign (misalign),
    .ld_valid (ld_valid)
);

// File: tb/lsa_unit_tb.sv
// Directed bench for lsa_unit with a 16-word lane-writable memory model.
module lsa_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  op_code = 6'h00;
    logic [31:0] base_val = '0;
    logic [15:0] ofs_imm = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] ld_result;
    logic        ld_valid;
    logic        misalign;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_code(op_code),
        .base_val(base_val), .ofs_imm(ofs_imm), .st_data(st_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .ld_result(ld_result),
        .ld_valid(ld_valid), .misalign(misalign)
    );

    // Memory model: lane writes and registered read.
    always_ff @(posedge clk) begin
        mem_rdata <= mem[mem_addr[5:2]];
        if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present a request at the falling edge and let it pass one rising edge.
    task automatic issue(input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; op_code = op; base_val = b; ofs_imm = o; st_data = d;
        #1;
    endtask

    task automatic release_req();
        @(negedge clk);
        req_valid = 1'b0; op_code = 6'h00;
    endtask

    task automatic store(input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d);
        issue(op, b, o, d);
        release_req();
    endtask

    task automatic load_chk(input string tag, input logic [5:0] op, input logic [31:0] b,
                            input logic [15:0] o, input logic [31:0] exp);
        issue(op, b, o, 32'h0);
        release_req();
        check({tag, " valid"}, {31'h0, ld_valid}, 32'h1);
        check(tag, ld_result, exp);
    endtask

    task automatic t_reset();
        check("R10 ld_valid after reset", {31'h0, ld_valid}, 32'h0);
        check("R10 ld_result after reset", ld_result, 32'h0);
        check("R9 idle be", {28'h0, mem_be}, 32'h0);
    endtask

    task automatic t_word_order();
        store(8'h2B, 32'h0, 16'h0, 32'h12345678);
        load_chk("R7 lw word 0", 6'h23, 32'h0, 16'h0, 32'h12345678);
        load_chk("R2 lbu offset 0", 6'h24, 32'h0, 16'h0, 32'h12);
        load_chk("R2 lbu offset 1", 6'h24, 32'h0, 16'h1, 32'h34);
        load_chk("R2 lbu offset 2", 6'h24, 32'h0, 16'h2, 32'h56);
        load_chk("R2 lbu offset 3", 6'h24, 32'h0, 16'h3, 32'h78);
    endtask

    task automatic t_lanes();
        for (int k = 0; k < 4; k++) begin
            issue(6'h28, 32'h20, 16'(k), 32'h000000A5);
            check("R2 sb be", {28'h0, mem_be}, 32'(4'b1000 >> k));
            check("R3 sb wdata", mem_wdata, 32'hA5A5A5A5);
            release_req();
        end
        issue(6'h29, 32'h20, 16'h0, 32'h0000BEEF);
        check("R2 sh be offset 0", {28'h0, mem_be}, 32'hC);
        check("R3 sh wdata", mem_wdata, 32'hBEEFBEEF);
        release_req();
        issue(6'h29, 32'h20, 16'h2, 32'h0000BEEF);
        check("R2 sh be offset 2", {28'h0, mem_be}, 32'h3);
        release_req();
        issue(6'h2B, 32'h20, 16'h0, 32'hCAFEF00D);
        check("R2 sw be", {28'h0, mem_be}, 32'hF);
        check("R3 sw wdata", mem_wdata, 32'hCAFEF00D);
        check("R4 sw we", {31'h0, mem_we}, 32'h1);
        release_req();
    endtask

    task automatic t_partial();
        store(6'h2B, 32'h4, 16'h0, 32'hAABBCCDD);
        store(6'h28, 32'h4, 16'h2, 32'hFFFFFF11);
        load_chk("R4 sb keeps other bytes", 6'h23, 32'h4, 16'h0, 32'hAABB11DD);
        store(6'h29, 32'h4, 16'h0, 32'h12345566);
        load_chk("R4 sh keeps low half", 6'h23, 32'h4, 16'h0, 32'h556611DD);
    endtask

    task automatic t_extend();
        store(6'h2B, 32'h8, 16'h0, 32'h80FF7F01);
        load_chk("R5 lb negative", 6'h20, 32'h8, 16'h0, 32'hFFFFFF80);
        load_chk("R6 lbu", 6'h24, 32'h8, 16'h0, 32'h00000080);
        load_chk("R5 lb positive", 6'h20, 32'h8, 16'h2, 32'h0000007F);
        load_chk("R5 lh negative", 6'h21, 32'h8, 16'h0, 32'hFFFF80FF);
        load_chk("R6 lhu", 6'h25, 32'h8, 16'h0, 32'h000080FF);
        load_chk("R5 lh positive", 6'h21, 32'h8, 16'h2, 32'h00007F01);
        load_chk("R5 lb byte 1", 6'h20, 32'h8, 16'h1, 32'hFFFFFFFF);
    endtask

    task automatic t_eff_addr();
        issue(6'h23, 32'h10, 16'hFFF8, 32'h0);
        check("R1 negative displacement", mem_addr, 32'h8);
        release_req();
        check("R1 load via negative displacement", ld_result, 32'h80FF7F01);
        issue(6'h23, 32'h3, 16'h5, 32'h0);
        check("R1 carry into word address", mem_addr, 32'h8);
        check("R8 aligned sum not flagged", {31'h0, misalign}, 32'h0);
        release_req();
        issue(6'h24, 32'h0000_0109, 16'h0, 32'h0);
        check("R1 address high bits", mem_addr, 32'h108);
        release_req();
    endtask

    task automatic t_misalign();
        issue(6'h2B, 32'h4, 16'h2, 32'hDEADBEEF);
        check("R8 sw flag", {31'h0, misalign}, 32'h1);
        check("R8 sw be", {28'h0, mem_be}, 32'h0);
        check("R8 sw we", {31'h0, mem_we}, 32'h0);
        release_req();
        load_chk("R8 memory untouched", 6'h23, 32'h4, 16'h0, 32'h556611DD);
        issue(6'h21, 32'h8, 16'h1, 32'h0);
        check("R8 lh odd flag", {31'h0, misalign}, 32'h1);
        release_req();
        check("R8 no result", {31'h0, ld_valid}, 32'h0);
        issue(6'h23, 32'h8, 16'h3, 32'h0);
        check("R8 lw offset 3 flag", {31'h0, misalign}, 32'h1);
        release_req();
        issue(6'h29, 32'h4, 16'h3, 32'h0);
        check("R8 sh odd flag", {31'h0, misalign}, 32'h1);
        release_req();
        issue(6'h21, 32'h8, 16'h2, 32'h0);
        check("R8 lh even not flagged", {31'h0, misalign}, 32'h0);
        release_req();
        issue(6'h20, 32'h8, 16'h3, 32'h0);
        check("R8 lb any offset not flagged", {31'h0, misalign}, 32'h0);
        release_req();
    endtask

    task automatic t_unknown();
        issue(6'h22, 32'h4, 16'h1, 32'h11111111);
        check("R9 unknown be", {28'h0, mem_be}, 32'h0);
        check("R9 unknown we", {31'h0, mem_we}, 32'h0);
        check("R9 unknown misalign", {31'h0, misalign}, 32'h0);
        release_req();
        check("R9 unknown no result", {31'h0, ld_valid}, 32'h0);
        load_chk("R9 memory unchanged", 6'h23, 32'h4, 16'h0, 32'h556611DD);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_order();
        t_lanes();
        t_partial();
        t_extend();
        t_eff_addr();
        t_misalign();
        t_unknown();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule